// File: doc/BRIEF.md
# Command Ring Fetch Controller

The block is the consumer end of a circular command ring kept in memory. Software places 32-bit command words into the ring and then announces them by writing a new producer index into a register. The block holds its own consumer index and, while enabled and the two indices differ, it reads words from memory one at a time, stepping the consumer index and wrapping it at the end of the ring. Fetched words pass through a small internal FIFO to a downstream valid/ready output.

Software sees the progress of the block in three ways: the consumer index is readable as a register, it is copied to a chosen memory address each time it moves (unless that copy is switched off), and a space register gives the number of free bytes a producer may still fill. A status register reports the free FIFO slots, a busy flag for the fetch engine and a flag for any activity at all. The ring holds a power-of-two number of words, set by a log2 parameter; equal indices mean an empty ring, so a producer always leaves one word unused.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: After reset the consumer index reads 0, fetching is disabled, no memory request or write-back is raised, the output is not valid and STATUS reads the full FIFO depth as free slots with both flags clear.
- R2: While CTRL bit 0 (enable) is 0, no memory read request is raised, whatever the two indices are.
- R3: With enable set, the block requests ring words at byte address BASE + 4 × index, starting at the consumer index and stopping before the producer index; the index wraps to 0 after the last ring word.
- R4: Returned words appear on the output in request order, and an offered word and its data stay put until the consumer takes it.
- R5: The number of requests accepted but not yet delivered never exceeds the FIFO depth; once it equals the depth, no request is raised.
- R6: The consumer index (register offset 3, read-only) increments by one, modulo the ring size, exactly on each cycle a read request is accepted, and holds otherwise.
- R7: A write to WPTR (offset 2) keeps only the low log2(ring size) bits as the producer index; bit 31 is a separate flag that reads back as written and has no effect on fetching.
- R8: After the consumer index changes, a write of the new index is issued to the address in WBADDR (offset 4) and the last such write carries the final index; with CTRL bit 1 set, no write-back is issued.
- R9: SPACE (offset 6) reads (consumer − producer) mod ring size, with 0 replaced by the ring size, times 4, in bytes.
- R10: STATUS (offset 5) holds the free FIFO slots in bits 11:0, in bit 16 a flag set when enabled with differing indices or requests outstanding, and in bit 31 a flag that is also set while the FIFO holds words or a write-back is pending; other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_waddr | input | 3 | Register write offset (0 CTRL, 1 BASE, 2 WPTR, 4 WBADDR) |
| host_wdata | input | 32 | Register write data |
| host_raddr | input | 3 | Register read offset |
| host_rdata | output | 32 | Register read data, one cycle after the offset |
| mem_req | output | 1 | Ring read request |
| mem_addr | output | AW | Byte address of the requested ring word |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data returned, in request order |
| mem_rdata | input | 32 | Returned ring word |
| wb_req | output | 1 | Index write-back request |
| wb_addr | output | AW | Write-back byte address |
| wb_data | output | 32 | Consumer index being written back |
| wb_gnt | input | 1 | Write-back accepted this cycle |
| cmd_valid | output | 1 | Command word available |
| cmd_data | output | 32 | Command word |
| cmd_ready | input | 1 | Downstream takes the word |

## Verification
The bench builds the block with a 16-word ring and a 4-entry FIFO. With a ring that small the index passes the wrap point many times in the random rounds and a directed case crosses it on purpose, and four words are enough to fill the FIFO, so holding the consumer off drives the block into its credit stall within a few cycles. Memory grants, returns and write-back grants are random, so requests and returns overlap with index updates and write-backs in many different orders.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
  localparam logic [2:0] RG_CTRL  = 3'd0;
  localparam logic [2:0] RG_BASE  = 3'd1;
  localparam logic [2:0] RG_WPTR  = 3'd2;
  localparam logic [2:0] RG_RPTR  = 3'd3;
  localparam logic [2:0] RG_WBADR = 3'd4;
  localparam logic [2:0] RG_STAT  = 3'd5;
  localparam logic [2:0] RG_SPACE = 3'd6;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_WBOFF_BIT = 1;
  localparam int WPTR_FLAG_BIT  = 31;
  localparam int STAT_CNT_W     = 12;
  localparam int STAT_BUSY_BIT  = 16;
  localparam int STAT_ACT_BIT   = 31;
endpackage

// File: rtl/rfc_regs.sv
module rfc_regs
  import rfc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int RING_L2 = 6,
  parameter int SPACE_W = RING_L2 + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2:0]         waddr,
  input  logic [31:0]        wdata,
  input  logic [2:0]         raddr,
  output logic [31:0]        rdata,
  input  logic [RING_L2-1:0] rptr,
  input  logic [SPACE_W-1:0] space_bytes,
  input  logic [STAT_CNT_W-1:0] free_slots,
  input  logic               busy,
  input  logic               active,
  output logic               en,
  output logic               wb_off,
  output logic [AW-1:0]      base,
  output logic [AW-1:0]      wbaddr,
  output logic [RING_L2-1:0] wptr,
  output logic               flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      wb_off <= 1'b0;
      base   <= '0;
      wbaddr <= '0;
      wptr   <= '0;
      flag   <= 1'b0;
    end else if (we) begin
      case (waddr)
        RG_CTRL: begin
          en     <= wdata[CTRL_EN_BIT];
          wb_off <= wdata[CTRL_WBOFF_BIT];
        end
        RG_BASE:  base   <= wdata[AW-1:0];
        RG_WPTR: begin
          wptr <= wdata[RING_L2-1:0];
          flag <= wdata[WPTR_FLAG_BIT];
        end
        RG_WBADR: wbaddr <= wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  logic [31:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[STAT_CNT_W-1:0] = free_slots;
    stat_word[STAT_BUSY_BIT]  = busy;
    stat_word[STAT_ACT_BIT]   = active;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (raddr)
        RG_CTRL:  rdata <= {30'd0, wb_off, en};
        RG_BASE:  rdata <= 32'(base);
        RG_WPTR:  rdata <= {flag, (31 - RING_L2)'(0), wptr};
        RG_RPTR:  rdata <= 32'(rptr);
        RG_WBADR: rdata <= 32'(wbaddr);
        RG_STAT:  rdata <= stat_word;
        RG_SPACE: rdata <= 32'(space_bytes);
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/rfc_fetch.sv
module rfc_fetch #(
  parameter int AW      = 32,
  parameter int RING_L2 = 6,
  parameter int FIFO_L2 = 3,
  localparam int DEPTH   = 1 << FIFO_L2,
  localparam int CW      = FIFO_L2 + 1,
  localparam int SPACE_W = RING_L2 + 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [AW-1:0]      base,
  input  logic [RING_L2-1:0] wptr,
  input  logic               mem_gnt,
  input  logic               mem_rvalid,
  input  logic [CW-1:0]      fifo_cnt,
  output logic               mem_req,
  output logic [AW-1:0]      mem_addr,
  output logic [RING_L2-1:0] rptr,
  output logic               rptr_adv,
  output logic               busy,
  output logic [SPACE_W-1:0] space_bytes
);
  localparam logic [RING_L2:0] RING_WORDS = (RING_L2+1)'(1) << RING_L2;

  logic [RING_L2-1:0] rptr_q;
  logic [CW-1:0]      infl_q;
  logic [CW:0]        committed;
  logic               have_work;
  logic               has_credit;

  assign committed  = {1'b0, infl_q} + {1'b0, fifo_cnt};
  assign have_work  = (rptr_q != wptr);
  assign has_credit = committed < (CW+1)'(DEPTH);
  assign mem_req    = en && have_work && has_credit;
  assign rptr_adv   = mem_req && mem_gnt;
  assign mem_addr   = base + AW'({rptr_q, 2'b00});
  assign rptr       = rptr_q;
  assign busy       = (en && have_work) || (infl_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
    end else if (rptr_adv) begin
      rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      infl_q <= '0;
    end else begin
      case ({rptr_adv, mem_rvalid})
        2'b10:   infl_q <= infl_q + 1'b1;
        2'b01:   infl_q <= infl_q - 1'b1;
        default: infl_q <= infl_q;
      endcase
    end
  end

  logic [RING_L2-1:0] gap;
  logic [RING_L2:0]   space_words;
  always_comb begin
    gap = rptr_q - wptr;
    space_words = (gap == '0) ? RING_WORDS : {1'b0, gap};
    space_bytes = {space_words, 2'b00};
  end
endmodule

// File: rtl/rfc_fifo.sv
module rfc_fifo #(
  parameter int W  = 32,
  parameter int L2 = 3,
  localparam int DEPTH = 1 << L2,
  localparam int CW    = L2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [L2-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign out_valid = (cnt_q != '0);
  assign pop       = out_valid && out_ready;
  assign out_data  = store[rp_q];
  assign count     = cnt_q;

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rfc_wb.sv
module rfc_wb #(
  parameter int AW      = 32,
  parameter int RING_L2 = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               off,
  input  logic               adv,
  input  logic [RING_L2-1:0] rptr,
  input  logic [AW-1:0]      wbaddr,
  input  logic               wb_gnt,
  output logic               wb_req,
  output logic [AW-1:0]      wb_addr,
  output logic [31:0]        wb_data,
  output logic               pending
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst || off) begin
      pend_q <= 1'b0;
    end else if (adv) begin
      pend_q <= 1'b1;
    end else if (wb_gnt) begin
      pend_q <= 1'b0;
    end
  end

  assign wb_req  = pend_q && !off;
  assign wb_addr = wbaddr;
  assign wb_data = 32'(rptr);
  assign pending = pend_q;
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
  import rfc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int RING_L2 = 6,
  parameter int FIFO_L2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [2:0]    host_waddr,
  input  logic [31:0]   host_wdata,
  input  logic [2:0]    host_raddr,
  output logic [31:0]   host_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          wb_req,
  output logic [AW-1:0] wb_addr,
  output logic [31:0]   wb_data,
  input  logic          wb_gnt,
  output logic          cmd_valid,
  output logic [31:0]   cmd_data,
  input  logic          cmd_ready
);
  localparam int DEPTH   = 1 << FIFO_L2;
  localparam int CW      = FIFO_L2 + 1;
  localparam int SPACE_W = RING_L2 + 3;

  logic               ctl_en, ctl_wboff, ptr_flag;
  logic [AW-1:0]      ring_base, wb_target;
  logic [RING_L2-1:0] prod_ptr, cons_ptr;
  logic               cons_adv, fetch_busy, wb_pend;
  logic [SPACE_W-1:0] space_bytes;
  logic [CW-1:0]      fifo_cnt;
  logic [STAT_CNT_W-1:0] free_slots;
  logic               any_active;

  assign free_slots = STAT_CNT_W'(CW'(DEPTH) - fifo_cnt);
  assign any_active = fetch_busy || (fifo_cnt != '0) || wb_pend;

  rfc_regs #(.AW(AW), .RING_L2(RING_L2), .SPACE_W(SPACE_W)) u_regs (
    .clk(clk), .rst(rst), .we(host_we), .waddr(host_waddr), .wdata(host_wdata),
    .raddr(host_raddr), .rdata(host_rdata), .rptr(cons_ptr), .space_bytes(space_bytes),
    .free_slots(free_slots), .busy(fetch_busy), .active(any_active),
    .en(ctl_en), .wb_off(ctl_wboff), .base(ring_base), .wbaddr(wb_target),
    .wptr(prod_ptr), .flag(ptr_flag)
  );

  rfc_fetch #(.AW(AW), .RING_L2(RING_L2), .FIFO_L2(FIFO_L2)) u_fetch (
    .clk(clk), .rst(rst), .en(ctl_en), .base(ring_base), .wptr(prod_ptr),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .fifo_cnt(fifo_cnt),
    .mem_req(mem_req), .mem_addr(mem_addr), .rptr(cons_ptr), .rptr_adv(cons_adv),
    .busy(fetch_busy), .space_bytes(space_bytes)
  );

  rfc_fifo #(.W(32), .L2(FIFO_L2)) u_fifo (
    .clk(clk), .rst(rst), .push(mem_rvalid), .din(mem_rdata),
    .out_valid(cmd_valid), .out_data(cmd_data), .out_ready(cmd_ready), .count(fifo_cnt)
  );

  rfc_wb #(.AW(AW), .RING_L2(RING_L2)) u_wb (
    .clk(clk), .rst(rst), .off(ctl_wboff), .adv(cons_adv), .rptr(cons_ptr),
    .wbaddr(wb_target), .wb_gnt(wb_gnt), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_data(wb_data), .pending(wb_pend)
  );
endmodule

// File: rtl/rfc_chk.sv
module rfc_chk #(
  parameter int RING_L2 = 6,
  parameter int FIFO_L2 = 3,
  localparam int DEPTH = 1 << FIFO_L2,
  localparam int CW    = FIFO_L2 + 1
) (
  input logic               clk,
  input logic               rst,
  input logic               en,
  input logic               wb_off,
  input logic               mem_req,
  input logic               mem_gnt,
  input logic               mem_rvalid,
  input logic [RING_L2-1:0] rptr,
  input logic [RING_L2-1:0] wptr,
  input logic               wb_req,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [31:0]        cmd_data,
  input logic [CW-1:0]      fifo_cnt
);
  p_off_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !en |-> !mem_req);

  p_empty_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (rptr == wptr) |-> !mem_req);

  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    mem_rvalid |-> (fifo_cnt < CW'(DEPTH)));

  p_rptr_step_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_gnt) |=> (rptr == RING_L2'($past(rptr) + 1'b1)));

  p_rptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && mem_gnt) |=> $stable(rptr));

  p_wb_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    wb_off |-> !wb_req);
endmodule

bind ring_fetch_ctrl rfc_chk #(.RING_L2(RING_L2), .FIFO_L2(FIFO_L2)) u_chk (
  .clk(clk), .rst(rst), .en(ctl_en), .wb_off(ctl_wboff), .mem_req(mem_req),
  .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .rptr(cons_ptr), .wptr(prod_ptr),
  .wb_req(wb_req), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_ring_fetch_ctrl.sv
module sim_ring_fetch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RL2   = 4;
  localparam int FL2   = 2;
  localparam int RING  = 1 << RL2;
  localparam int DEPTH = 1 << FL2;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] WBA  = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [2:0]  host_waddr = '0;
  logic [31:0] host_wdata = '0;
  logic [2:0]  host_raddr = '0;
  logic [31:0] host_rdata;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        wb_req;
  logic [31:0] wb_addr;
  logic [31:0] wb_data;
  logic        wb_gnt = 1'b0;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int n_acc = 0, n_del = 0, wb_cnt = 0;
  int acc_idx = 0, del_idx = 0;
  logic [31:0] last_wb = '0;
  logic [31:0] q [64];
  int qh = 0, qt = 0;
  bit hold = 1'b0;
  bit done_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_fetch_ctrl #(.AW(32), .RING_L2(RL2), .FIFO_L2(FL2)) u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_data(wb_data), .wb_gnt(wb_gnt),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return (a * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] space_of(input int r, input int w);
    int g = ((r - w) % RING + RING) % RING;
    if (g == 0) g = RING;
    return 32'(g * 4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    host_raddr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic drain(input int goal);
    int t = 0;
    while (n_del != goal && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (30) @(negedge clk);
  endtask

  // memory, consumer and write-back responders
  initial begin
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_gnt = 0; mem_rvalid = 0; cmd_ready = 0; wb_gnt = 0;
      end else begin
        mem_gnt = ($urandom % 4) != 0;
        if (mem_req && mem_gnt) begin
          chk("R3 fetch address", mem_addr, BASE + 32'(4 * acc_idx));
          q[qt % 64] = mem_addr; qt++;
          acc_idx = (acc_idx + 1) % RING;
          n_acc++;
        end
        if (qh != qt && ($urandom % 3) != 0) begin
          mem_rvalid = 1'b1; mem_rdata = word_at(q[qh % 64]); qh++;
        end else begin
          mem_rvalid = 1'b0;
        end
        cmd_ready = hold ? 1'b0 : (($urandom % 4) != 0);
        if (cmd_valid && cmd_ready) begin
          chk("R4 word order", cmd_data, word_at(BASE + 32'(4 * del_idx)));
          del_idx = (del_idx + 1) % RING;
          n_del++;
        end
        wb_gnt = ($urandom % 2) != 0;
        if (wb_req && wb_gnt) begin
          chk("R8 write-back address", wb_addr, WBA);
          last_wb = wb_data; wb_cnt++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int goal, cur, wbc;
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mem_req idle", 32'(mem_req), 0);
    chk("R1 wb_req idle", 32'(wb_req), 0);
    chk("R1 cmd_valid idle", 32'(cmd_valid), 0);
    rd(3'd3, v); chk("R1 rptr zero", v, 0);
    rd(3'd5, v); chk("R1 status", v, 32'(DEPTH));
    rd(3'd6, v); chk("R9 space empty ring", v, space_of(0, 0));

    wr(3'd1, BASE);
    wr(3'd4, WBA);
    wr(3'd2, 32'h8000_0005);
    repeat (20) @(negedge clk);
    chk("R2 no fetch while disabled", 32'(n_acc), 0);
    rd(3'd2, v); chk("R7 flag readback", v, 32'h8000_0005);
    rd(3'd6, v); chk("R9 space", v, space_of(0, 5));

    wr(3'd0, 32'h1);
    drain(5);
    chk("R3 stop before wptr", 32'(n_acc), 5);
    rd(3'd3, v); chk("R6 rptr", v, 5);
    chk("R8 final write-back", last_wb, 5);
    rd(3'd5, v); chk("R10 idle status", v, 32'(DEPTH));

    wr(3'd2, 32'h0000_0017);
    drain(7);
    rd(3'd3, v); chk("R7 masked wptr", v, 7);
    rd(3'd2, v); chk("R7 flag cleared", v, 32'h7);

    // back-pressure stall
    hold = 1'b1;
    wr(3'd2, 32'd15);
    repeat (60) @(negedge clk);
    chk("R5 outstanding at depth", 32'(n_acc - n_del), 32'(DEPTH));
    chk("R5 request withheld", 32'(mem_req), 0);
    rd(3'd5, v); chk("R10 stalled status", v, 32'h8001_0000);
    rd(3'd6, v); chk("R9 space mid", v, space_of(7 + DEPTH, 15));
    hold = 1'b0;
    drain(15);

    // wrap
    wr(3'd2, 32'd3);
    drain(19);
    rd(3'd3, v); chk("R3 wrap rptr", v, 3);
    chk("R8 write-back after wrap", last_wb, 3);

    // write-back suppressed
    wr(3'd0, 32'h3);
    wbc = wb_cnt;
    wr(3'd2, 32'd6);
    drain(22);
    chk("R8 no write-back when off", 32'(wb_cnt), 32'(wbc));
    rd(3'd3, v); chk("R6 rptr off", v, 6);

    // disable mid-stream
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd10);
    repeat (30) @(negedge clk);
    chk("R2 disabled hold", 32'(n_acc), 22);
    rd(3'd5, v); chk("R10 disabled status", v, 32'(DEPTH));
    wr(3'd0, 32'h1);
    drain(26);
    rd(3'd6, v); chk("R9 space after drain", v, space_of(10, 10));

    // random rounds
    cur = 10; goal = 26;
    for (int i = 0; i < 40; i++) begin
      int k = 1 + ($urandom % (RING - 1));
      hold = ($urandom % 5) == 0;
      cur = (cur + k) % RING;
      goal += k;
      wr(3'd2, ($urandom % 2) ? (32'(cur) | 32'h8000_0000) : 32'(cur));
      repeat (10) @(negedge clk);
      hold = 1'b0;
      drain(goal);
      rd(3'd3, v); chk("R6 random rptr", v, 32'(cur));
      chk("R8 random write-back", last_wb, 32'(cur));
    end
    chk("R3 total fetched", 32'(n_acc), 32'(goal));

    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule